// File: doc/BRIEF.md
# Nonvolatile SRAM Power-Fail Save/Restore Sequencer

This block controls a battery-free nonvolatile SRAM across power loss and power return. It watches two comparator flags: one says the supply has fallen below the switch threshold, and the other says it has fallen below the reset threshold. It also watches a strobe that marks each completed host write to the SRAM. When the supply falls, it saves the SRAM array into shadow nonvolatile cells. This save has two ordered phases: erase, then program. When the supply returns after a deep drop, it restores the shadow contents into the array.

A save is skipped on power loss if the array has not been written since the last save or restore finished. Software can request a save at any time the sequencer is idle, and that save always runs. A restore request is latched while the supply is below the reset threshold, and at power-up. It is served only once the supply rises back above the switch threshold. The block drives a busy flag that fences off the host port. It also gives the array-copy engine one-cycle start pulses for each phase. The phase lengths are parameters counted in clock cycles.

Top module: `nvsram_pwr_seq`

## Requirements
- R1: During reset and afterwards, the sequencer is in the power-wait state (`state_o` = 4) with a restore request pending and `busy_o` high. With the supply good, the first clock edge after reset moves it to the restore state (`state_o` = 3) with a `restore_go_o` pulse.
- R2: In idle (`state_o` = 0) with the array written since the last save or restore, a high `vlow_switch_i` moves the sequencer to the erase state (`state_o` = 1) on the next edge, with one `erase_go_o` pulse. This is well within `SAVE_LAT_NS`.
- R3: In idle with no write since the last save or restore, a high `vlow_switch_i` moves the sequencer to power-wait (`state_o` = 4), and no erase pulse is given.
- R4: A `sw_save_i` pulse in idle starts a save (`state_o` = 1, `erase_go_o`) whether or not the array has been written. While `vlow_switch_i` is high, the power-loss decision takes priority.
- R5: A save stays exactly `ERASE_CYC` cycles in erase. It then stays exactly `PROG_CYC` cycles in program (`state_o` = 2), and `prog_go_o` pulses in the first program cycle. At most one go pulse is high at a time.
- R6: A high `vlow_reset_i` latches a restore request. From power-wait with `vlow_switch_i` low, a pending request starts a restore that lasts exactly `RESTORE_CYC` cycles before idle. Without a pending request, power-wait returns straight to idle.
- R7: `busy_o` is high in every state except idle. Write strobes and `sw_save_i` that arrive while busy have no effect.
- R8: The written flag is cleared when a save or a restore completes. A later power loss with no new write therefore does not save.
- R9: A rise of `vlow_switch_i` during a restore abandons it on the next edge and goes to power-wait with no save. The request stays pending, and the restore reruns in full once the supply recovers.
- R10: A save runs to completion even if power is lost during it. It ends in power-wait if `vlow_switch_i` is high and in idle otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| vlow_switch_i | input | 1 | Supply below switch threshold |
| vlow_reset_i | input | 1 | Supply below reset threshold |
| wr_done_i | input | 1 | One pulse per completed host write |
| sw_save_i | input | 1 | Software save request pulse |
| busy_o | output | 1 | Host port fenced off (data outputs held off) |
| state_o | output | 3 | Current state code: 0 idle, 1 erase, 2 program, 3 restore, 4 power-wait |
| erase_go_o | output | 1 | Start pulse for the erase phase |
| prog_go_o | output | 1 | Start pulse for the program phase |
| restore_go_o | output | 1 | Start pulse for the restore phase |

## Verification
Some rules are checked on every cycle. These are the one-edge response to power loss depending on the written flag, the one-hot go pulses, the order of erase before program, the abandonment of a restore on power loss with the request kept, the clearing of the written flag after a save, and the power-wait to restore start. Only the bench scenarios can show the rest. These are the exact phase lengths, that writes and save requests during busy periods leave no trace, and that a brownout without a reset-level drop returns to idle without a restore. They also cover the rerun of an abandoned restore at full length. The bench sweeps every combination of written/clean and power-loss/software trigger.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_ERASE   = 3'd1,
      ST_PROG    = 3'd2,
      ST_RESTORE = 3'd3,
      ST_PWAIT   = 3'd4
   } nvseq_state_e;
endpackage

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart_i,
   input  logic [CW-1:0] dur_i,
   output logic          last_o
);
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (restart_i)  cnt_q <= '0;
      else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = (cnt_q == dur_i - 1'b1);
endmodule

// File: rtl/nvseq_flags.sv
module nvseq_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   input  logic busy_i,
   input  logic vlow_reset_i,
   input  logic save_done_i,
   input  logic restore_done_i,
   output logic dirty_o,
   output logic pend_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         dirty_o <= 1'b0;
      else if (save_done_i || restore_done_i) dirty_o <= 1'b0;
      else if (wr_i && !busy_i)           dirty_o <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pend_o <= 1'b1;
      else if (vlow_reset_i)   pend_o <= 1'b1;
      else if (restore_done_i) pend_o <= 1'b0;
   end
endmodule

// File: rtl/nvseq_fsm.sv
module nvseq_fsm
   import nvseq_pkg::*;
#(
   parameter int CW          = 4,
   parameter int ERASE_CYC   = 3,
   parameter int PROG_CYC    = 4,
   parameter int RESTORE_CYC = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vlow_sw_i,
   input  logic          sw_req_i,
   input  logic          dirty_i,
   input  logic          pend_i,
   input  logic          last_i,
   output logic          restart_o,
   output logic [CW-1:0] dur_o,
   output logic          save_done_o,
   output logic          restore_done_o,
   output nvseq_state_e  state_o,
   output logic          erase_go_o,
   output logic          prog_go_o,
   output logic          restore_go_o
);
   nvseq_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (vlow_sw_i)     state_d = dirty_i ? ST_ERASE : ST_PWAIT;
            else if (sw_req_i) state_d = ST_ERASE;
         end
         ST_ERASE:   if (last_i) state_d = ST_PROG;
         ST_PROG:    if (last_i) state_d = vlow_sw_i ? ST_PWAIT : ST_IDLE;
         ST_RESTORE: begin
            if (vlow_sw_i)   state_d = ST_PWAIT;
            else if (last_i) state_d = ST_IDLE;
         end
         ST_PWAIT:   if (!vlow_sw_i) state_d = pend_i ? ST_RESTORE : ST_IDLE;
         default:    state_d = ST_PWAIT;
      endcase
   end

   always_comb begin
      unique case (state_q)
         ST_ERASE:   dur_o = CW'(ERASE_CYC);
         ST_PROG:    dur_o = CW'(PROG_CYC);
         default:    dur_o = CW'(RESTORE_CYC);
      endcase
   end

   assign restart_o      = (state_d != state_q);
   assign save_done_o    = (state_q == ST_PROG) && last_i;
   assign restore_done_o = (state_q == ST_RESTORE) && last_i && !vlow_sw_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_PWAIT;
         erase_go_o   <= 1'b0;
         prog_go_o    <= 1'b0;
         restore_go_o <= 1'b0;
      end else begin
         state_q      <= state_d;
         erase_go_o   <= restart_o && (state_d == ST_ERASE);
         prog_go_o    <= restart_o && (state_d == ST_PROG);
         restore_go_o <= restart_o && (state_d == ST_RESTORE);
      end
   end

   assign state_o = state_q;
endmodule

// File: rtl/nvsram_pwr_seq.sv
module nvsram_pwr_seq
   import nvseq_pkg::*;
#(
   parameter int CLK_NS      = 10,
   parameter int SAVE_LAT_NS = 500,
   parameter int ERASE_CYC   = 3,
   parameter int PROG_CYC    = 4,
   parameter int RESTORE_CYC = 5,
   parameter bit SW_SAVE_EN  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       vlow_switch_i,
   input  logic       vlow_reset_i,
   input  logic       wr_done_i,
   input  logic       sw_save_i,
   output logic       busy_o,
   output logic [2:0] state_o,
   output logic       erase_go_o,
   output logic       prog_go_o,
   output logic       restore_go_o
);
   localparam int SAVE_LAT_CYC = SAVE_LAT_NS / CLK_NS;
   localparam int MAX_DUR = (ERASE_CYC > PROG_CYC)
                            ? ((ERASE_CYC > RESTORE_CYC) ? ERASE_CYC : RESTORE_CYC)
                            : ((PROG_CYC > RESTORE_CYC) ? PROG_CYC : RESTORE_CYC);
   localparam int CW = $clog2(MAX_DUR + 1);

   if (ERASE_CYC < 1 || PROG_CYC < 1 || RESTORE_CYC < 1) begin : g_bad_dur
      $error("phase durations must be at least one cycle");
   end
   if (SAVE_LAT_CYC < 1) begin : g_bad_lat
      $error("save latency bound shorter than one clock period");
   end

   logic sw_req;
   if (SW_SAVE_EN) begin : g_sw_on
      assign sw_req = sw_save_i;
   end else begin : g_sw_off
      logic sw_unused;
      assign sw_unused = sw_save_i;
      assign sw_req    = 1'b0;
   end

   logic          dirty_w, pend_w, last_w, restart_w, save_done_w, restore_done_w;
   logic [CW-1:0] dur_w;
   nvseq_state_e  state_w;

   nvseq_flags u_flags (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_i           (wr_done_i),
      .busy_i         (busy_o),
      .vlow_reset_i   (vlow_reset_i),
      .save_done_i    (save_done_w),
      .restore_done_i (restore_done_w),
      .dirty_o        (dirty_w),
      .pend_o         (pend_w)
   );

   nvseq_timer #(.CW(CW)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart_w),
      .dur_i     (dur_w),
      .last_o    (last_w)
   );

   nvseq_fsm #(
      .CW(CW), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .RESTORE_CYC(RESTORE_CYC)
   ) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .vlow_sw_i      (vlow_switch_i),
      .sw_req_i       (sw_req && !busy_o),
      .dirty_i        (dirty_w),
      .pend_i         (pend_w),
      .last_i         (last_w),
      .restart_o      (restart_w),
      .dur_o          (dur_w),
      .save_done_o    (save_done_w),
      .restore_done_o (restore_done_w),
      .state_o        (state_w),
      .erase_go_o     (erase_go_o),
      .prog_go_o      (prog_go_o),
      .restore_go_o   (restore_go_o)
   );

   assign state_o = state_w;
   assign busy_o  = (state_w != ST_IDLE);
endmodule

// File: rtl/nvseq_chk.sv
module nvseq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       vlow_switch_i,
   input logic [2:0] state_o,
   input logic       erase_go_o,
   input logic       prog_go_o,
   input logic       restore_go_o,
   input logic       dirty,
   input logic       pend
);
   assert_save_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd0 && vlow_switch_i && dirty) |=> (state_o == 3'd1 && erase_go_o));

   assert_clean_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd0 && vlow_switch_i && !dirty) |=> (state_o == 3'd4 && !erase_go_o));

   assert_go_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({erase_go_o, prog_go_o, restore_go_o}));

   assert_erase_then_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd1) |=> (state_o == 3'd1 || (state_o == 3'd2 && prog_go_o)));

   assert_restore_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd4 && !vlow_switch_i && pend) |=> (state_o == 3'd3 && restore_go_o));

   assert_dirty_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != 3'd2 && $past(state_o) == 3'd2) |-> !dirty);

   assert_restore_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd3 && vlow_switch_i) |=> (state_o == 3'd4 && pend && !erase_go_o));
endmodule

bind nvsram_pwr_seq nvseq_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .vlow_switch_i (vlow_switch_i),
   .state_o       (state_o),
   .erase_go_o    (erase_go_o),
   .prog_go_o     (prog_go_o),
   .restore_go_o  (restore_go_o),
   .dirty         (dirty_w),
   .pend          (pend_w)
);

// File: tb/nvsram_pwr_seq_tb.sv
module nvsram_pwr_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int E_CYC = 3;
   localparam int P_CYC = 4;
   localparam int R_CYC = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vsw = 1'b0, vrst = 1'b0, wr = 1'b0, sw = 1'b0;
   logic busy, eg, pg, rg;
   logic [2:0] st;
   int n_chk = 0, n_fail = 0, cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nvsram_pwr_seq #(.CLK_NS(CLK_PERIOD), .ERASE_CYC(E_CYC), .PROG_CYC(P_CYC),
                    .RESTORE_CYC(R_CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .vlow_switch_i(vsw), .vlow_reset_i(vrst),
      .wr_done_i(wr), .sw_save_i(sw), .busy_o(busy), .state_o(st),
      .erase_go_o(eg), .prog_go_o(pg), .restore_go_o(rg));

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // counts consecutive sampled cycles in state s, starting with the current one
   task automatic phase_len(input int s, input int exp, input string req);
      int n = 0;
      while (int'(st) == s && n < 100) begin
         chk("R7 busy in phase", busy, 1);
         n++;
         tick();
      end
      chk(req, n, exp);
   endtask

   task automatic pulse_wr();
      wr = 1'b1; tick(); wr = 1'b0;
   endtask

   initial begin
      while (cyc < 20000) begin @(posedge clk); cyc++; end
      n_fail++;
      $display("FAIL watchdog: actual %0d expected 0 cycles left", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      tick(); tick();
      chk("R1 reset state", st, 4);
      chk("R1 reset busy", busy, 1);
      rst_n = 1'b1;
      tick();
      chk("R1 restore after reset", st, 3);
      chk("R1 restore pulse", rg, 1);
      phase_len(3, R_CYC, "R6 restore length");
      chk("R6 idle after restore", st, 0);
      chk("R7 idle not busy", busy, 0);

      // sweep: written/clean x power-loss/software trigger
      for (int w = 0; w < 2; w++) begin
         for (int m = 0; m < 2; m++) begin
            if (w == 1) pulse_wr();
            if (m == 0) begin
               vsw = 1'b1; tick();
               if (w == 1) begin
                  chk("R2 erase entered", st, 1);
                  chk("R2 erase pulse", eg, 1);
                  phase_len(1, E_CYC, "R5 erase length");
                  chk("R5 prog pulse", pg, 1);
                  phase_len(2, P_CYC, "R5 prog length");
                  chk("R10 pwait after save", st, 4);
               end else begin
                  chk("R3 clean skip", st, 4);
                  chk("R3 no erase pulse", eg, 0);
               end
               vsw = 1'b0; tick();
               chk("R6 brownout back to idle", st, 0);
            end else begin
               sw = 1'b1; tick(); sw = 1'b0;
               chk("R4 sw save starts", st, 1);
               chk("R4 sw erase pulse", eg, 1);
               phase_len(1, E_CYC, "R5 erase length sw");
               phase_len(2, P_CYC, "R5 prog length sw");
               chk("R10 idle after sw save", st, 0);
               vsw = 1'b1; tick();
               chk("R8 cleared after save", st, 4);
               vsw = 1'b0; tick();
               chk("R8 back idle", st, 0);
            end
         end
      end

      // writes and save requests while busy are ignored
      sw = 1'b1; tick(); sw = 1'b0;
      chk("R4 sw save again", st, 1);
      wr = 1'b1; sw = 1'b1; tick(); wr = 1'b0; sw = 1'b0;
      phase_len(1, E_CYC - 1, "R7 erase rest");
      pulse_wr();
      phase_len(2, P_CYC - 1, "R7 prog rest");
      chk("R7 idle after save", st, 0);
      tick();
      chk("R7 no extra save", st, 0);
      vsw = 1'b1; tick();
      chk("R7 writes ignored while busy", st, 4);

      // deep drop latches restore; abort on power loss; full rerun
      vrst = 1'b1; tick(); vrst = 1'b0;
      pulse_wr();
      vsw = 1'b0; tick();
      chk("R6 latched restore starts", st, 3);
      tick(); tick();
      vsw = 1'b1; tick();
      chk("R9 restore abandoned", st, 4);
      chk("R9 no erase", eg, 0);
      tick();
      chk("R9 still waiting", st, 4);
      vsw = 1'b0; tick();
      chk("R9 restore rerun", st, 3);
      phase_len(3, R_CYC, "R9 full restore length");
      chk("R9 idle after rerun", st, 0);

      // power lost during a save: save completes, then power-wait
      pulse_wr();
      sw = 1'b1; tick(); sw = 1'b0;
      vsw = 1'b1;
      phase_len(1, E_CYC, "R10 erase under power loss");
      phase_len(2, P_CYC, "R10 prog under power loss");
      chk("R10 pwait", st, 4);
      vsw = 1'b0; tick();
      chk("R6 no pending restore", st, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule